// File: doc/BRIEF.md
# Asynchronous Bus Master Cycle Sequencer

This block is the bus-facing half of a processor: it takes one transfer request at a time and turns it into a single read or write cycle on a 16-bit asynchronous bus. The bus has a word address, one address strobe, one data strobe per byte lane and a read/write line. The cycle is split into eight half-clock states, S0 to S7. The block runs from a clock at twice the bus clock rate, so each state lasts exactly one `clk` period. It keeps a phase bit and drives the bus clock `bus_clk` from it. Even-numbered states are the high half of `bus_clk`. Odd-numbered states are the low half. The end of an even state is therefore a falling bus-clock edge.

The state set is IDLE, S0 to S7, WA and WB. The transitions are:
- IDLE to S0 (accept) is taken at the end of a low half when `req_valid` is high.
- S0 to S1 to S2 to S3 to S4 always advance.
- S4 to S5 (ack seen) or S4 to WA (no ack) is decided by the acknowledge sampled at the end of S4.
- WA to WB always advances.
- WB to S5 (ack seen) or WB to WA (no ack) is decided by the acknowledge sampled at the end of WB.
- S5 to S6 to S7 to IDLE (finish) always advance.

Each WA/WB pair is one whole wait clock. Read data is captured at the end of S6. `done` pulses for one tick in the IDLE tick that follows S7.

Top module: `bus_master_seq`

## Requirements
- R1: While `rst_n` is low and after it is released, with no request pending: `bus_as_n` and every `bus_ds_n` bit are 1, `bus_rw` is 1, `bus_dout_en`, `busy` and `done` are 0, and `bus_addr` is 0.
- R2: A request (`req_valid` high) is accepted only in IDLE, at the end of a tick in which `bus_clk` is low. S0 always falls in a `bus_clk`-high tick. `busy` is 1 from S0 through S7. A request held while busy is ignored: the address on the bus stays that of the running transfer, and no second transfer starts at the `done` tick.
- R3: `bus_addr` shows the latched request address from S1 through S7, including wait states, and is 0 otherwise.
- R4: On a read (`req_write`=0), `bus_as_n` and the enabled data strobes are low from S2 through S7, and `bus_rw` stays 1.
- R5: On a write, `bus_as_n` is low and `bus_rw` is 0 from S2. `bus_dout_en` is 1 with the request data on `bus_dout` from S3. The enabled data strobes go low from S4. All of these hold through S7.
- R6: Data strobe bit i is asserted only when `req_be[i]` is 1. Lane 1 carries `data[15:8]` and lane 0 carries `data[7:0]`. With `req_be` = 0 no data strobe is asserted.
- R7: `bus_dtack_n` is sampled at the end of S4 and at the end of each WB. If it is 1 there, one whole wait clock (WA, WB) is inserted. With W wait clocks, `done` is 1 exactly 8+2W ticks after the S0 tick.
- R8: `bus_dtack_n` low only during a WA tick (the high-to-low half is never sampled) is ignored and does not shorten the cycle.
- R9: On a read, `bus_din` is captured at the end of S6 and shown on `rdata` from the `done` tick. `done` is high for exactly one tick.
- R10: After S7, `bus_as_n`, all data strobes and `bus_rw` return high, `bus_dout_en` returns to 0, and `busy` is 0 in the `done` tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-state clock, twice the bus clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Transfer request, held until `busy` rises |
| req_write | input | 1 | 1 = write, 0 = read |
| req_be | input | 2 | Byte-lane enables (bit 1 = upper lane) |
| req_addr | input | 23 | Word address |
| req_wdata | input | 16 | Write data |
| busy | output | 1 | A transfer is in progress (S0..S7) |
| done | output | 1 | One-tick completion pulse |
| rdata | output | 16 | Data captured on the last read |
| bus_clk | output | 1 | Bus clock, high during even states |
| bus_addr | output | 23 | Bus address |
| bus_as_n | output | 1 | Address strobe, active low |
| bus_ds_n | output | 2 | Per-lane data strobes, active low |
| bus_rw | output | 1 | 1 = read, 0 = write |
| bus_dout | output | 16 | Write data to the bus |
| bus_dout_en | output | 1 | Write data drive enable |
| bus_din | input | 16 | Read data from the bus |
| bus_dtack_n | input | 1 | Transfer acknowledge, active low |

## Verification
Both directions are swept against every byte-enable value and against zero to three wait clocks. Every tick of every cycle is compared with the expected strobe, address, drive-enable and completion state for that half-state. This separates the read and write strobe timing and the lane gating. It also shows whether each acknowledge delay adds exactly two ticks. The read data is presented only in the tick that ends S6, with its complement on either side, so a capture one tick early or late gives the wrong word. Separate runs pulse the acknowledge in a WA tick only, and hold a second request during a transfer. These show that unsampled phases and busy-time requests have no effect on the bus.

// File: rtl/bms_pkg.sv
package bms_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_S0, ST_S1, ST_S2, ST_S3,
        ST_S4, ST_S5, ST_S6, ST_S7,
        ST_WA, ST_WB
    } bms_state_e;
endpackage

// File: rtl/bms_fsm.sv
module bms_fsm
    import bms_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic       dtack_n,
    output bms_state_e state,
    output logic       phase,
    output logic       accept
);
    bms_state_e state_nx;

    // phase 0: bus clock high half, phase 1: low half
    assign accept = (state == ST_IDLE) && req_valid && phase;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            phase <= 1'b0;
        end else begin
            state <= state_nx;
            phase <= ~phase;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (accept) state_nx = ST_S0;
            ST_S0:   state_nx = ST_S1;
            ST_S1:   state_nx = ST_S2;
            ST_S2:   state_nx = ST_S3;
            ST_S3:   state_nx = ST_S4;
            ST_S4:   state_nx = dtack_n ? ST_WA : ST_S5;
            ST_WA:   state_nx = ST_WB;
            ST_WB:   state_nx = dtack_n ? ST_WA : ST_S5;
            ST_S5:   state_nx = ST_S6;
            ST_S6:   state_nx = ST_S7;
            ST_S7:   state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // R2: cycle starts on the high half of the bus clock
    assert_s0_high_half_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_S0) |-> !phase);
    // R7: a missing acknowledge at a sample point inserts a wait clock
    assert_wait_inserted_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_S4 || state == ST_WB) && dtack_n) |=> (state == ST_WA));
    // R8: acknowledge in WA never ends the wait
    assert_wa_not_sampled_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WA) |=> (state == ST_WB));
endmodule

// File: rtl/bms_outdec.sv
module bms_outdec
    import bms_pkg::*;
#(
    parameter int AW = 23,
    parameter int NB = 2
) (
    input  bms_state_e        state,
    input  logic              wr,
    input  logic [NB-1:0]     be,
    input  logic [AW-1:0]     addr_q,
    output logic [AW-1:0]     addr,
    output logic              as_n,
    output logic [NB-1:0]     ds_n,
    output logic              rw,
    output logic              dout_en
);
    logic in_cycle;   // S1..S7 and waits
    logic strobed;    // S2..S7 and waits
    logic late;       // S4..S7 and waits
    logic data_win;   // S3..S7 and waits
    logic ds_on;

    always_comb begin
        in_cycle = 1'b0;
        strobed  = 1'b0;
        late     = 1'b0;
        data_win = 1'b0;
        unique case (state)
            ST_IDLE, ST_S0: ;
            ST_S1: in_cycle = 1'b1;
            ST_S2: begin in_cycle = 1'b1; strobed = 1'b1; end
            ST_S3: begin in_cycle = 1'b1; strobed = 1'b1; data_win = 1'b1; end
            ST_S4, ST_S5, ST_S6, ST_S7, ST_WA, ST_WB: begin
                in_cycle = 1'b1; strobed = 1'b1; data_win = 1'b1; late = 1'b1;
            end
            default: ;
        endcase
    end

    assign ds_on   = strobed && (!wr || late);
    assign addr    = in_cycle ? addr_q : '0;
    assign as_n    = !strobed;
    assign rw      = !(wr && strobed);
    assign dout_en = wr && data_win;

    for (genvar i = 0; i < NB; i++) begin : g_lane
        assign ds_n[i] = !(ds_on && be[i]);
    end
endmodule

// File: rtl/bus_master_seq.sv
module bus_master_seq
    import bms_pkg::*;
#(
    parameter int AW = 23,
    parameter int DW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [DW/8-1:0]   req_be,
    input  logic [AW-1:0]     req_addr,
    input  logic [DW-1:0]     req_wdata,
    output logic              busy,
    output logic              done,
    output logic [DW-1:0]     rdata,
    output logic              bus_clk,
    output logic [AW-1:0]     bus_addr,
    output logic              bus_as_n,
    output logic [DW/8-1:0]   bus_ds_n,
    output logic              bus_rw,
    output logic [DW-1:0]     bus_dout,
    output logic              bus_dout_en,
    input  logic [DW-1:0]     bus_din,
    input  logic              bus_dtack_n
);
    localparam int NB = DW / 8;

    bms_state_e       state;
    logic             phase;
    logic             accept;
    logic             wr_q;
    logic [NB-1:0]    be_q;
    logic [AW-1:0]    addr_q;
    logic [DW-1:0]    wdata_q;
    logic [DW-1:0]    rdata_q;
    logic             done_q;

    bms_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .dtack_n   (bus_dtack_n),
        .state     (state),
        .phase     (phase),
        .accept    (accept)
    );

    bms_outdec #(.AW(AW), .NB(NB)) u_outdec (
        .state   (state),
        .wr      (wr_q),
        .be      (be_q),
        .addr_q  (addr_q),
        .addr    (bus_addr),
        .as_n    (bus_as_n),
        .ds_n    (bus_ds_n),
        .rw      (bus_rw),
        .dout_en (bus_dout_en)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q    <= 1'b0;
            be_q    <= '0;
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
            done_q  <= 1'b0;
        end else begin
            if (accept) begin
                wr_q    <= req_write;
                be_q    <= req_be;
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
            end
            if (state == ST_S6 && !wr_q) rdata_q <= bus_din;
            done_q <= (state == ST_S7);
        end
    end

    assign busy     = (state != ST_IDLE);
    assign done     = done_q;
    assign rdata    = rdata_q;
    assign bus_clk  = !phase;
    assign bus_dout = wdata_q;

    // R4/R5: no data strobe without the address strobe
    assert_ds_within_as_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ds_n != '1) |-> !bus_as_n);
    // R5: write data is driven whenever a write strobe is active
    assert_wr_data_driven_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_rw && bus_ds_n != '1) |-> bus_dout_en);
    // R5: direction does not change while the address strobe is held
    assert_rw_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_as_n && $past(!bus_as_n)) |-> $stable(bus_rw));
    // R9: completion is a single-tick pulse
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R2: a transfer begins only from a request
    assert_busy_from_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(req_valid));
    // R10: the bus is released once done is raised
    assert_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (bus_as_n && !bus_dout_en));
endmodule

// File: tb/tb_bus_master_seq.sv
module tb_bus_master_seq;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 23;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [1:0]    req_be = '0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          busy, done, bus_clk, bus_as_n, bus_rw, bus_dout_en;
    logic [DW-1:0] rdata, bus_dout;
    logic [AW-1:0] bus_addr;
    logic [1:0]    bus_ds_n;
    logic [DW-1:0] bus_din = '0;
    logic          bus_dtack_n = 1'b1;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bus_master_seq #(.AW(AW), .DW(DW)) dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_be(req_be),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .busy(busy), .done(done), .rdata(rdata), .bus_clk(bus_clk),
        .bus_addr(bus_addr), .bus_as_n(bus_as_n), .bus_ds_n(bus_ds_n),
        .bus_rw(bus_rw), .bus_dout(bus_dout), .bus_dout_en(bus_dout_en),
        .bus_din(bus_din), .bus_dtack_n(bus_dtack_n)
    );

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // half-state index at tick k of a cycle with w waits: 0..7 = S0..S7, 8 = wait, 9 = idle
    function automatic int hstate(input int k, input int w);
        if (k <= 5) return k - 1;
        if (k <= 5 + 2*w) return 8;
        if (k <= 8 + 2*w) return k - 2*w - 1;
        return 9;
    endfunction

    task automatic xfer(input bit wr, input logic [1:0] be, input logic [AW-1:0] a,
                        input logic [DW-1:0] wd, input int w, input bit spur, input bit busyreq);
        logic [DW-1:0] pat;
        int guard;
        pat = wd ^ 16'h5A3C;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_be = be; req_addr = a; req_wdata = wd;
        guard = 0;
        while (!busy && guard < 6) begin
            @(negedge clk);
            guard++;
        end
        chk("R2", "busy after request", {31'd0, busy}, 32'd1);
        if (busyreq) begin
            req_addr = ~a; req_write = !wr; req_be = ~be;
        end else begin
            req_valid = 1'b0;
        end
        for (int k = 1; k <= 10 + 2*w; k++) begin
            int h;
            bit as_on, ds_on, dout_on, addr_on, end_ph;
            string ctl;
            h = hstate(k, w);
            as_on   = (h >= 2 && h <= 8);
            addr_on = (h >= 1 && h <= 8);
            ds_on   = as_on && (!wr || h >= 4);
            dout_on = wr && h >= 3 && h <= 8;
            end_ph  = (k >= 9 + 2*w);
            ctl = end_ph ? "R10" : (wr ? "R5" : "R4");
            chk(busyreq ? "R2" : "R3", "bus_addr", 32'(bus_addr), addr_on ? 32'(a) : 32'd0);
            chk(ctl, "bus_as_n", {31'd0, bus_as_n}, {31'd0, !as_on});
            chk(ctl, "bus_rw", {31'd0, bus_rw}, {31'd0, !(wr && as_on)});
            chk(end_ph ? "R10" : "R6", "bus_ds_n", 32'(bus_ds_n),
                32'({!(ds_on && be[1]), !(ds_on && be[0])}));
            chk(end_ph ? "R10" : "R5", "bus_dout_en", {31'd0, bus_dout_en}, {31'd0, dout_on});
            if (dout_on) chk("R5", "bus_dout", 32'(bus_dout), 32'(wd));
            chk("R2", "busy", {31'd0, busy}, {31'd0, h <= 8});
            chk(spur ? "R8" : (w > 0 ? "R7" : "R9"), "done", {31'd0, done},
                {31'd0, k == 9 + 2*w});
            if (k == 1 || k == 5) chk("R2", "bus_clk high", {31'd0, bus_clk}, 32'd1);
            if (k == 9 + 2*w && !wr) chk("R9", "rdata", 32'(rdata), 32'(pat));
            // drive the target side for this tick
            bus_dtack_n = !((k >= 5 + 2*w && k <= 8 + 2*w) || (spur && k == 6));
            bus_din = (k == 7 + 2*w) ? pat : ~pat;
            if (busyreq && k == 9 + 2*w) req_valid = 1'b0;
            @(negedge clk);
        end
        bus_dtack_n = 1'b1;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "as_n in reset", {31'd0, bus_as_n}, 32'd1);
        chk("R1", "ds_n in reset", 32'(bus_ds_n), 32'd3);
        chk("R1", "rw in reset", {31'd0, bus_rw}, 32'd1);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1", "busy after reset", {31'd0, busy}, 32'd0);
        chk("R1", "done after reset", {31'd0, done}, 32'd0);
        chk("R1", "addr after reset", 32'(bus_addr), 32'd0);
        chk("R1", "dout_en after reset", {31'd0, bus_dout_en}, 32'd0);

        for (int wr = 0; wr < 2; wr++)
            for (int w = 0; w < 4; w++)
                for (int b = 0; b < 4; b++)
                    xfer(wr[0], 2'(b), 23'h2A5000 + 23'(wr*64 + w*8 + b),
                         16'hC3A1 + 16'(w*257 + b*4099 + wr*31), w, 1'b0, 1'b0);
        // R8: acknowledge only in a WA tick is ignored
        xfer(1'b0, 2'b11, 23'h012345, 16'h1234, 2, 1'b1, 1'b0);
        xfer(1'b1, 2'b01, 23'h054321, 16'hBEEF, 3, 1'b1, 1'b0);
        // R2: request held while busy is ignored
        xfer(1'b1, 2'b10, 23'h7F00AA, 16'h0F0F, 1, 1'b0, 1'b1);
        xfer(1'b0, 2'b11, 23'h00FF55, 16'h9999, 0, 1'b0, 1'b1);
        repeat (4) @(negedge clk);
        chk("R2", "idle after ignored request", {31'd0, busy}, 32'd0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule